// File: doc/BRIEF.md
# Decode-Stage Branch Hazard Unit

This block detects read-after-write hazards for branches and register jumps that compare their operands in the decode stage of a five-stage pipeline. It compares the source registers that the decode-stage branch asks for against the destinations of the instructions now in the execute and memory stages. On a conflict it raises a stall. The stall freezes the program counter and the fetch-to-decode register, and it puts a bubble into the execute stage.

A mode input picks between two policies. In stall-only mode, any conflict with execute or memory stalls. In forwarding mode, a conflict with the memory stage is resolved by a forward path and needs no stall. The exception is a load in the memory stage: its data arrives in the same cycle that the program counter is being computed, so it cannot be forwarded in time and the branch must stall. Each stall decision is stored as a bit in the decode-to-execute record so that it travels with the pipeline. A small wrapper holds the program counter and the stage registers, so the unit can be driven from an instruction source.

Top module: `brhz_pipe`

## Requirements
- R1: After a clock edge with `rst_n` low, `pc` is 0, `stall` is 0, and `ex_wr`, `mem_wr`, `mem_load` and `ex_stall` are 0.
- R2: `stall` is 1 whenever the execute-stage instruction writes a nonzero destination equal to a requested decode source, in both modes.
- R3: With `mode_fwd` = 0, `stall` is 1 when the memory-stage instruction writes a nonzero destination equal to a requested decode source.
- R4: With `mode_fwd` = 1, a memory-stage match still raises `stall` when that instruction is a load (`mem_load` = 1).
- R5: With `mode_fwd` = 1, a memory-stage match by a non-load raises no stall; `fwd_a` or `fwd_b` is 1 for the matching operand (a is the first source, b the second). Both are 0 whenever `stall` is 1.
- R6: A destination of register 0 never causes a stall or a forward.
- R7: A source whose request flag (`f_need_a`, `f_need_b`) is 0 is never compared.
- R8: In a cycle with `stall` = 1, the next edge leaves `pc` and the fetch-to-decode instruction unchanged.
- R9: In a cycle with `stall` = 1, the next edge loads a bubble into execute (`ex_wr` = 0) with `ex_stall` = 1. On a non-stall edge, `ex_stall` becomes 0.
- R10: In a cycle with `stall` = 0, the next edge adds 4 to `pc` and moves each stage forward by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_fwd | input | 1 | 0 stall-only, 1 stall plus forwarding |
| f_src_a | input | 5 | First source register of the fetched instruction |
| f_src_b | input | 5 | Second source register of the fetched instruction |
| f_need_a | input | 1 | Branch compare needs the first source |
| f_need_b | input | 1 | Branch compare needs the second source |
| f_dst | input | 5 | Destination register of the fetched instruction |
| f_wr | input | 1 | Fetched instruction writes a register |
| f_load | input | 1 | Fetched instruction is a load |
| pc | output | PC_W | Program counter addressing the instruction source |
| stall | output | 1 | Hazard stall for the current cycle |
| fwd_a | output | 1 | First source taken from the memory-stage forward |
| fwd_b | output | 1 | Second source taken from the memory-stage forward |
| ex_stall | output | 1 | Stall bit carried in the execute-stage record |
| ex_wr | output | 1 | Execute-stage instruction writes a register |
| ex_dst | output | 5 | Execute-stage destination |
| mem_wr | output | 1 | Memory-stage instruction writes a register |
| mem_dst | output | 5 | Memory-stage destination |
| mem_load | output | 1 | Memory-stage instruction is a load |

## Verification
The assertions check, on every cycle, the relations between stage state and the stall: an execute match or a memory-stage load match always stalls, a forward never happens together with a stall, a stall holds the counter and bubbles execute, and a free cycle advances the counter by four. Only the bench scenarios can show the exact cycle in which each stall begins and ends for load-then-branch and ALU-then-branch sequences in both modes. The same holds for the one-instruction gap case, where only the memory stage conflicts, and for the cases where register 0 or a cleared request flag must leave the pipeline running freely.

// File: rtl/brhz_pkg.sv
// Shared widths and the per-stage control record of the hazard pipeline.
// Assumes a 32-entry register file with register 0 hard-wired to zero.
package brhz_pkg;
    localparam int REG_W = 5;
    localparam int N_SRC = 2;

    typedef struct packed {
        logic [N_SRC-1:0][REG_W-1:0] src;
        logic [N_SRC-1:0]            need;
        logic [REG_W-1:0]            dst;
        logic                        wr;
        logic                        load;
    } stage_ctl_t;

    localparam stage_ctl_t BUBBLE = '0;
endpackage

// File: rtl/brhz_match.sv
// Compares each requested decode source with one later stage's destination.
// Assumes dst 0 is the constant zero register and never a real producer.
module brhz_match
    import brhz_pkg::*;
(
    input  logic [N_SRC-1:0][REG_W-1:0] src,
    input  logic [N_SRC-1:0]            need,
    input  logic [REG_W-1:0]            dst,
    input  logic                        wr,
    output logic [N_SRC-1:0]            hit
);
    logic producer_ok;

    // A stage can only conflict if it really writes a nonzero register.
    always_comb producer_ok = wr && (dst != '0);

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        // Per-source equality, gated by the request flag.
        always_comb hit[i] = producer_ok && need[i] && (src[i] == dst);
    end
endmodule

// File: rtl/brhz_detect.sv
// Hazard decision for a decode-stage branch: stall or forward.
// Assumes execute results are never forwardable to decode in time, and that
// memory-stage load data arrives too late for the branch compare.
module brhz_detect
    import brhz_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        mode_fwd,
    input  stage_ctl_t                  dec,
    input  stage_ctl_t                  exe,
    input  stage_ctl_t                  mem,
    output logic                        stall,
    output logic [N_SRC-1:0]            fwd
);
    logic [N_SRC-1:0] ex_hit;
    logic [N_SRC-1:0] mem_hit;
    logic             mem_blocks;

    brhz_match u_ex_match (
        .src  (dec.src),
        .need (dec.need),
        .dst  (exe.dst),
        .wr   (exe.wr),
        .hit  (ex_hit)
    );

    brhz_match u_mem_match (
        .src  (dec.src),
        .need (dec.need),
        .dst  (mem.dst),
        .wr   (mem.wr),
        .hit  (mem_hit)
    );

    // Memory-stage conflicts stall unless forwarding is on and data is ready.
    always_comb mem_blocks = (mem_hit != '0) && (!mode_fwd || mem.load);

    // Final stall: any execute conflict or a blocking memory conflict.
    always_comb stall = (ex_hit != '0) || mem_blocks;

    // Forward selects are only meaningful when the branch proceeds.
    always_comb fwd = (mode_fwd && !stall) ? mem_hit : '0;

    a_r2_ex_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_hit != '0) |-> stall);
    a_r4_load_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_hit != '0) && mem.load) |-> stall);
    a_r5_fwd_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd != '0) |-> !stall);
    a_r3_stall_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_fwd && (mem_hit != '0)) |-> (stall && fwd == '0));
endmodule

// File: rtl/brhz_stage_regs.sv
// Program counter and fetch/decode, decode/execute, execute/memory registers.
// Assumes a stall freezes fetch and decode and sends a bubble to execute.
module brhz_stage_regs
    import brhz_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int PC_STEP = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stall,
    input  stage_ctl_t      fetch_ctl,
    output logic [PC_W-1:0] pc,
    output stage_ctl_t      dec,
    output stage_ctl_t      exe,
    output logic            exe_stall,
    output stage_ctl_t      mem
);
    localparam logic [PC_W-1:0] STEP = PC_W'(PC_STEP);

    // Program counter: advance on free cycles, hold on stall.
    always_ff @(posedge clk) begin
        if (!rst_n)      pc <= '0;
        else if (!stall) pc <= pc + STEP;
    end

    // Fetch-to-decode register: capture on free cycles, hold on stall.
    always_ff @(posedge clk) begin
        if (!rst_n)      dec <= BUBBLE;
        else if (!stall) dec <= fetch_ctl;
    end

    // Decode-to-execute record with stall bit; a stall injects a bubble.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exe       <= BUBBLE;
            exe_stall <= 1'b0;
        end else begin
            exe       <= stall ? BUBBLE : dec;
            exe_stall <= stall;
        end
    end

    // Execute-to-memory register: always advances.
    always_ff @(posedge clk) begin
        if (!rst_n) mem <= BUBBLE;
        else        mem <= exe;
    end

    a_r8_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && $past(rst_n)) |=> (pc == $past(pc) && dec == $past(dec)));
    a_r9_bubble: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (!exe.wr && !exe.load && exe_stall));
    a_r10_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && $past(rst_n)) |=> (pc == $past(pc) + STEP && !exe_stall));
endmodule

// File: rtl/brhz_pipe.sv
// Top: decode-stage branch hazard unit with its stage registers.
// Assumes the instruction source answers combinationally for the current pc.
module brhz_pipe
    import brhz_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_fwd,
    input  logic [4:0]       f_src_a,
    input  logic [4:0]       f_src_b,
    input  logic             f_need_a,
    input  logic             f_need_b,
    input  logic [4:0]       f_dst,
    input  logic             f_wr,
    input  logic             f_load,
    output logic [PC_W-1:0]  pc,
    output logic             stall,
    output logic             fwd_a,
    output logic             fwd_b,
    output logic             ex_stall,
    output logic             ex_wr,
    output logic [4:0]       ex_dst,
    output logic             mem_wr,
    output logic [4:0]       mem_dst,
    output logic             mem_load
);
    stage_ctl_t       fetch_ctl;
    stage_ctl_t       dec;
    stage_ctl_t       exe;
    stage_ctl_t       mem;
    logic [N_SRC-1:0] fwd;

    // Pack the fetched instruction fields into the stage record.
    always_comb begin
        fetch_ctl.src  = {f_src_b, f_src_a};
        fetch_ctl.need = {f_need_b, f_need_a};
        fetch_ctl.dst  = f_dst;
        fetch_ctl.wr   = f_wr;
        fetch_ctl.load = f_load;
    end

    brhz_stage_regs #(.PC_W(PC_W), .PC_STEP(4)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .stall     (stall),
        .fetch_ctl (fetch_ctl),
        .pc        (pc),
        .dec       (dec),
        .exe       (exe),
        .exe_stall (ex_stall),
        .mem       (mem)
    );

    brhz_detect u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_fwd (mode_fwd),
        .dec      (dec),
        .exe      (exe),
        .mem      (mem),
        .stall    (stall),
        .fwd      (fwd)
    );

    // Expose stage state and forward selects.
    always_comb begin
        fwd_a    = fwd[0];
        fwd_b    = fwd[1];
        ex_wr    = exe.wr;
        ex_dst   = exe.dst;
        mem_wr   = mem.wr;
        mem_dst  = mem.dst;
        mem_load = mem.load;
    end

    a_r6_zero_never: assert property (@(posedge clk) disable iff (!rst_n)
        (exe.dst == '0 && mem.dst == '0) |-> (!stall && fwd == '0));
endmodule

// File: tb/tb_brhz_pipe.sv
module tb_brhz_pipe;
    localparam int CLK_PERIOD = 10;
    localparam int NCYC = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_fwd = 1'b0;
    logic [4:0]  f_src_a, f_src_b, f_dst;
    logic        f_need_a, f_need_b, f_wr, f_load;
    logic [31:0] pc;
    logic        stall, fwd_a, fwd_b, ex_stall, ex_wr, mem_wr, mem_load;
    logic [4:0]  ex_dst, mem_dst;

    int n_chk = 0;
    int n_bad = 0;

    // program store, one entry per word address
    logic [4:0] p_a [8], p_b [8], p_d [8];
    logic       p_na [8], p_nb [8], p_w [8], p_l [8];

    // per-cycle samples
    logic        s_st [1:NCYC], s_fa [1:NCYC], s_fb [1:NCYC];
    logic        s_exs [1:NCYC], s_exw [1:NCYC];
    logic [31:0] s_pc [1:NCYC];

    always #(CLK_PERIOD/2) clk = ~clk;

    brhz_pipe #(.PC_W(32)) dut (
        .clk(clk), .rst_n(rst_n), .mode_fwd(mode_fwd),
        .f_src_a(f_src_a), .f_src_b(f_src_b), .f_need_a(f_need_a),
        .f_need_b(f_need_b), .f_dst(f_dst), .f_wr(f_wr), .f_load(f_load),
        .pc(pc), .stall(stall), .fwd_a(fwd_a), .fwd_b(fwd_b),
        .ex_stall(ex_stall), .ex_wr(ex_wr), .ex_dst(ex_dst),
        .mem_wr(mem_wr), .mem_dst(mem_dst), .mem_load(mem_load)
    );

    // instruction source: combinational lookup at the current pc
    always_comb begin
        if (pc < 32'd32) begin
            f_src_a  = p_a[pc[4:2]];
            f_src_b  = p_b[pc[4:2]];
            f_need_a = p_na[pc[4:2]];
            f_need_b = p_nb[pc[4:2]];
            f_dst    = p_d[pc[4:2]];
            f_wr     = p_w[pc[4:2]];
            f_load   = p_l[pc[4:2]];
        end else begin
            f_src_a = '0; f_src_b = '0; f_need_a = 0; f_need_b = 0;
            f_dst = '0; f_wr = 0; f_load = 0;
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 8; i++) begin
            p_a[i] = '0; p_b[i] = '0; p_d[i] = '0;
            p_na[i] = 0; p_nb[i] = 0; p_w[i] = 0; p_l[i] = 0;
        end
    endtask

    task automatic set_writer(input int idx, input logic [4:0] d, input logic ld);
        p_d[idx] = d; p_w[idx] = 1'b1; p_l[idx] = ld;
    endtask

    task automatic set_branch(input int idx, input logic [4:0] a, input logic na,
                              input logic [4:0] b, input logic nb);
        p_a[idx] = a; p_na[idx] = na; p_b[idx] = b; p_nb[idx] = nb;
    endtask

    // reset, then record NCYC samples, one after each edge
    task automatic run(input logic mode);
        mode_fwd = mode;
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        for (int c = 1; c <= NCYC; c++) begin
            @(negedge clk);
            s_st[c] = stall; s_fa[c] = fwd_a; s_fb[c] = fwd_b;
            s_exs[c] = ex_stall; s_exw[c] = ex_wr; s_pc[c] = pc;
        end
    endtask

    task automatic chk_stalls(input string req, input logic [NCYC-1:0] exp);
        for (int c = 1; c <= NCYC; c++)
            chk(req, s_st[c], exp[NCYC-c]);
    endtask

    task automatic t_reset();
        mode_fwd = 0;
        clear_prog();
        set_writer(0, 5'd3, 1'b1);
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R1 pc", pc, 0);
        chk("R1 stall", stall, 0);
        chk("R1 ex_wr", ex_wr, 0);
        chk("R1 mem_wr", mem_wr, 0);
        chk("R1 mem_load", mem_load, 0);
        chk("R1 ex_stall", ex_stall, 0);
    endtask

    // ALU writes r5, next instruction branches on r5
    task automatic t_alu_branch(input logic mode);
        clear_prog();
        set_writer(0, 5'd5, 1'b0);
        set_branch(1, 5'd5, 1'b1, 5'd9, 1'b0);
        run(mode);
        chk("R10 pc after first edge", s_pc[1], 4);
        chk("R2 ex conflict stall", s_st[2], 1);
        chk("R9 bubble ex_stall", s_exs[3], 1);
        chk("R9 bubble ex_wr", s_exw[3], 0);
        chk("R8 pc held", s_pc[3], 8);
        if (!mode) begin
            chk_stalls("R3 alu->branch stall-only", 6'b011000);
            chk("R8 pc still held", s_pc[4], 8);
            chk("R10 pc resumes", s_pc[5], 12);
        end else begin
            chk_stalls("R5 alu->branch forward", 6'b010000);
            chk("R5 fwd_a", s_fa[3], 1);
            chk("R5 fwd_b", s_fb[3], 0);
            chk("R10 pc resumes", s_pc[4], 12);
            chk("R9 ex_stall clears", s_exs[4], 0);
        end
    endtask

    // load writes r6, next instruction branches on r6 (second source)
    task automatic t_load_branch(input logic mode);
        clear_prog();
        set_writer(0, 5'd6, 1'b1);
        set_branch(1, 5'd2, 1'b0, 5'd6, 1'b1);
        run(mode);
        chk_stalls(mode ? "R4 load->branch forward mode" : "R3 load->branch stall-only",
                   6'b011000);
        chk("R4 no fwd_b on load", s_fb[3], 0);
        chk("R8 pc held", s_pc[4], 8);
    endtask

    // one-instruction gap: only the memory stage conflicts
    task automatic t_gap(input logic mode, input logic ld);
        clear_prog();
        set_writer(0, 5'd7, ld);
        set_branch(2, 5'd1, 1'b0, 5'd7, 1'b1);
        run(mode);
        if (!mode || ld) begin
            chk_stalls(ld ? "R4 gap load" : "R3 gap stall-only", 6'b001000);
            chk("R8 pc held gap", s_pc[4], 12);
        end else begin
            chk_stalls("R5 gap forward", 6'b000000);
            chk("R5 gap fwd_b", s_fb[3], 1);
            chk("R5 gap fwd_a", s_fa[3], 0);
        end
    endtask

    // writer to r0 and unrequested sources must never stall
    task automatic t_no_hazard(input logic mode);
        clear_prog();
        set_writer(0, 5'd0, 1'b1);
        set_branch(1, 5'd0, 1'b1, 5'd0, 1'b1);
        run(mode);
        chk_stalls("R6 register zero", 6'b000000);
        chk("R6 no forward", s_fa[3] | s_fb[3], 0);
        chk("R10 pc free run", s_pc[6], 24);
        clear_prog();
        set_writer(0, 5'd4, 1'b0);
        set_branch(1, 5'd4, 1'b0, 5'd4, 1'b0);
        run(mode);
        chk_stalls("R7 flags clear", 6'b000000);
        chk("R7 no forward", s_fa[3] | s_fb[3], 0);
    endtask

    initial begin
        clear_prog();
        t_reset();
        for (int m = 0; m < 2; m++) begin
            t_alu_branch(m[0]);
            t_load_branch(m[0]);
            t_gap(m[0], 1'b0);
            t_gap(m[0], 1'b1);
            t_no_hazard(m[0]);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule